// File: doc/BRIEF.md
# Serial Controller Data FIFO Pair

This block holds the byte buffering that sits between a register bus and a byte-oriented serial master engine. A transmit FIFO is filled through a data port and emptied by the engine. A receive FIFO is filled by the engine and emptied through the same data port. Each direction has its own programmable threshold. A service request is raised when a full threshold-sized chunk can be moved. A separate draining request is raised when the last part of a message is smaller than the threshold, so software or a DMA engine can move that final partial chunk without waiting for a threshold that will never be reached.

Software writes a 16-bit transfer count before each message. Two per-direction tracker state machines hold the bytes still to move. Each has three states: IDLE (nothing left), BULK (at least one threshold of bytes left) and TAIL (some bytes left, but fewer than the threshold). Every cycle a tracker takes its next state from its next remaining count. A count write sends it from any state to BULK or TAIL. Decrements move it BULK to BULK, BULK to TAIL, TAIL to TAIL, and finally TAIL to IDLE; if the threshold is 1 it goes straight from BULK to IDLE. A change of threshold reaches the tracker state one cycle after the configuration write. Transmit remaining counts down on each data-port write the transmit FIFO accepts. Receive remaining counts down on each byte the engine delivers.

Register map, selected by `reg_addr`: 0 data port, 1 buffer configuration, 2 buffer status, 3 transfer count, 4 FIFO levels. Reads return data in the same cycle, and a data-port read pops the receive FIFO on that clock edge. The FIFO depth is 8 << `DEPTH_CODE`.

Top module: `sfp_data_fifos`

## Requirements
- R1: After reset both FIFOs are empty, every request output is low, both error flags are 0, the count register reads 0, and both thresholds are 1.
- R2: A write to address 0 pushes `reg_wdata[7:0]` into the transmit FIFO, and the write is ignored when that FIFO is full. `core_tx_byte` shows the oldest transmit byte (0 when empty), and `core_pop` removes it, so bytes leave in write order.
- R3: `core_push` stores `core_rx_byte` in the receive FIFO. A read at address 0 returns the oldest byte and removes it. Reading an empty receive FIFO returns 0 and leaves its level at 0.
- R4: The configuration register (address 1) holds the transmit threshold minus one in bits [AW-1:0] and the receive threshold minus one in bits [8+AW-1:8], where AW = log2(depth). Bit 7 enables transmit DMA and bit 15 enables receive DMA. Bits 6 and 14 always read 0.
- R5: Writing configuration bit 6 empties the transmit FIFO and clears the underflow flag. Writing bit 14 empties the receive FIFO and clears the overrun flag. Neither bit stays set.
- R6: Status bits [15:14] (address 2) read `DEPTH_CODE`, and the depth is 8 shifted left by that value.
- R7: `tx_req` is high when the transmit tracker is in BULK and the free space is at least the transmit threshold.
- R8: `tx_drain_req` is high when the transmit tracker is in TAIL and the free space is at least the remaining count. While it is high, status bits [6:0] read the remaining transmit count.
- R9: `rx_req` is high when the receive level is at or above the receive threshold.
- R10: `rx_drain_req` is high when the receive tracker is in IDLE and the receive level is nonzero and below the threshold. While it is high and `tx_drain_req` is low, status bits [6:0] read the receive level.
- R11: A write to address 3 loads both remaining counts, and a written 0 is loaded as 1. Address 3 reads back the loaded value. Transmit remaining decrements on each accepted data-port write, and receive remaining decrements on each `core_push`; neither goes below 0.
- R12: Status bit 13 (overrun) sets when `core_push` arrives while the receive FIFO is full, and that byte is dropped. Status bit 12 (underflow) sets when `core_pop` arrives while the transmit FIFO is empty. Both flags stay set until cleared as in R5.
- R13: `tx_dma_req` equals the transmit DMA enable AND (`tx_req` OR `tx_drain_req`). `rx_dma_req` is formed the same way from the receive-side signals.
- R14: Address 4 reads the transmit level in bits [AW:0] and the receive level in bits [8+AW:8].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; pops the receive FIFO at address 0 |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, same cycle |
| core_push | input | 1 | Engine delivers a received byte |
| core_rx_byte | input | 8 | Received byte |
| core_pop | input | 1 | Engine takes a transmit byte |
| core_tx_byte | output | 8 | Oldest transmit byte, 0 when empty |
| tx_req | output | 1 | Transmit threshold request |
| tx_drain_req | output | 1 | Transmit final-chunk request |
| rx_req | output | 1 | Receive threshold request |
| rx_drain_req | output | 1 | Receive final-chunk request |
| tx_dma_req | output | 1 | Transmit DMA request level |
| rx_dma_req | output | 1 | Receive DMA request level |

## Verification
A wrong tracker state or remaining count appears at the request outputs on the next cycle. A ready request that should be a draining request, or one that is missing, is visible at once, and the drain field of the status register reads a wrong count. A wrong FIFO pointer or level appears at `core_tx_byte`, at the data port, or in the level register on the first access after the fault. The bench compares every request output, the transmit byte and the selected register against a model in every cycle, so any divergence is reported in the cycle where it first reaches a port.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
    typedef enum logic [1:0] {
        TRK_IDLE = 2'd0,
        TRK_BULK = 2'd1,
        TRK_TAIL = 2'd2
    } trk_phase_e;

    localparam logic [2:0] ADR_DATA = 3'd0;
    localparam logic [2:0] ADR_CFG  = 3'd1;
    localparam logic [2:0] ADR_STAT = 3'd2;
    localparam logic [2:0] ADR_CNT  = 3'd3;
    localparam logic [2:0] ADR_LVL  = 3'd4;

    localparam int CFG_TX_CLR  = 6;
    localparam int CFG_TX_DMA  = 7;
    localparam int CFG_RX_LSB  = 8;
    localparam int CFG_RX_CLR  = 14;
    localparam int CFG_RX_DMA  = 15;
    localparam int STAT_OVR    = 13;
    localparam int STAT_UDF    = 12;
    localparam int LVL_RX_LSB  = 8;
endpackage

// File: rtl/sfp_fifo.sv
module sfp_fifo #(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       push,
    input  logic [7:0]                 din,
    input  logic                       pop,
    output logic [7:0]                 dout,
    output logic [$clog2(DEPTH):0]     level,
    output logic                       full,
    output logic                       empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = AW + 1;

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign full    = (level == LW'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full && !clr;
    assign do_pop  = pop && !empty && !clr;
    assign dout    = empty ? 8'h00 : mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wp] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else if (clr) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/sfp_xfer_track.sv
module sfp_xfer_track
    import sfp_pkg::*;
#(
    parameter int THR_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [15:0]      load_val,
    input  logic             dec,
    input  logic [THR_W-1:0] thr,
    output logic [15:0]      left,
    output logic             is_idle,
    output logic             is_bulk,
    output logic             is_tail
);
    trk_phase_e  state_q, state_d;
    logic [15:0] left_d;
    logic [15:0] thr_ext;

    assign thr_ext = {{(16-THR_W){1'b0}}, thr};

    // next remaining count and next phase
    always_comb begin
        left_d = left;
        if (load) begin
            left_d = (load_val == 16'd0) ? 16'd1 : load_val;
        end else if (dec && left != 16'd0) begin
            left_d = left - 16'd1;
        end
        if (left_d == 16'd0) begin
            state_d = TRK_IDLE;
        end else if (left_d >= thr_ext) begin
            state_d = TRK_BULK;
        end else begin
            state_d = TRK_TAIL;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TRK_IDLE;
            left    <= 16'd0;
        end else begin
            state_q <= state_d;
            left    <= left_d;
        end
    end

    // outputs
    always_comb begin
        is_idle = 1'b0;
        is_bulk = 1'b0;
        is_tail = 1'b0;
        unique case (state_q)
            TRK_IDLE: is_idle = 1'b1;
            TRK_BULK: is_bulk = 1'b1;
            TRK_TAIL: is_tail = 1'b1;
            default:  is_idle = 1'b1;
        endcase
    end
endmodule

// File: rtl/sfp_data_fifos.sv
module sfp_data_fifos
    import sfp_pkg::*;
#(
    parameter int unsigned DEPTH_CODE = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [2:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    input  logic        core_push,
    input  logic [7:0]  core_rx_byte,
    input  logic        core_pop,
    output logic [7:0]  core_tx_byte,
    output logic        tx_req,
    output logic        tx_drain_req,
    output logic        rx_req,
    output logic        rx_drain_req,
    output logic        tx_dma_req,
    output logic        rx_dma_req
);
    localparam int DEPTH = 8 << DEPTH_CODE;
    localparam int AW    = $clog2(DEPTH);
    localparam int LW    = AW + 1;

    logic [AW-1:0] tx_thr_m1, rx_thr_m1;
    logic          tx_dma_en, rx_dma_en;
    logic          overrun_q, underflow_q;
    logic [15:0]   cnt_q;

    logic          wr_data, wr_cfg, wr_cnt, rd_data, tx_clr, rx_clr;
    logic [LW-1:0] tx_thr, rx_thr, tx_level, rx_level, tx_free, drain_cnt;
    logic          tx_full, tx_empty, rx_full, rx_empty;
    logic [7:0]    rx_head;
    logic [15:0]   tx_left, rx_left;
    logic          tx_idle, tx_bulk, tx_tail;
    logic          rx_idle, rx_bulk, rx_tail;

    assign wr_data = reg_wr && (reg_addr == ADR_DATA);
    assign wr_cfg  = reg_wr && (reg_addr == ADR_CFG);
    assign wr_cnt  = reg_wr && (reg_addr == ADR_CNT);
    assign rd_data = reg_rd && (reg_addr == ADR_DATA);
    assign tx_clr  = wr_cfg && reg_wdata[CFG_TX_CLR];
    assign rx_clr  = wr_cfg && reg_wdata[CFG_RX_CLR];

    assign tx_thr  = {1'b0, tx_thr_m1} + 1'b1;
    assign rx_thr  = {1'b0, rx_thr_m1} + 1'b1;
    assign tx_free = LW'(DEPTH) - tx_level;

    sfp_fifo #(.DEPTH(DEPTH)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n), .clr(tx_clr),
        .push(wr_data), .din(reg_wdata[7:0]),
        .pop(core_pop), .dout(core_tx_byte),
        .level(tx_level), .full(tx_full), .empty(tx_empty)
    );

    sfp_fifo #(.DEPTH(DEPTH)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr),
        .push(core_push), .din(core_rx_byte),
        .pop(rd_data), .dout(rx_head),
        .level(rx_level), .full(rx_full), .empty(rx_empty)
    );

    sfp_xfer_track #(.THR_W(LW)) u_tx_trk (
        .clk(clk), .rst_n(rst_n), .load(wr_cnt), .load_val(reg_wdata),
        .dec(wr_data && !tx_full), .thr(tx_thr), .left(tx_left),
        .is_idle(tx_idle), .is_bulk(tx_bulk), .is_tail(tx_tail)
    );

    sfp_xfer_track #(.THR_W(LW)) u_rx_trk (
        .clk(clk), .rst_n(rst_n), .load(wr_cnt), .load_val(reg_wdata),
        .dec(core_push), .thr(rx_thr), .left(rx_left),
        .is_idle(rx_idle), .is_bulk(rx_bulk), .is_tail(rx_tail)
    );

    // configuration, count and sticky error flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_thr_m1   <= '0;
            rx_thr_m1   <= '0;
            tx_dma_en   <= 1'b0;
            rx_dma_en   <= 1'b0;
            cnt_q       <= 16'd0;
            overrun_q   <= 1'b0;
            underflow_q <= 1'b0;
        end else begin
            if (wr_cfg) begin
                tx_thr_m1 <= reg_wdata[AW-1:0];
                rx_thr_m1 <= reg_wdata[CFG_RX_LSB +: AW];
                tx_dma_en <= reg_wdata[CFG_TX_DMA];
                rx_dma_en <= reg_wdata[CFG_RX_DMA];
            end
            if (wr_cnt) begin
                cnt_q <= (reg_wdata == 16'd0) ? 16'd1 : reg_wdata;
            end
            if (rx_clr) begin
                overrun_q <= 1'b0;
            end else if (core_push && rx_full) begin
                overrun_q <= 1'b1;
            end
            if (tx_clr) begin
                underflow_q <= 1'b0;
            end else if (core_pop && tx_empty) begin
                underflow_q <= 1'b1;
            end
        end
    end

    // service and draining requests
    assign tx_req       = tx_bulk && (tx_free >= tx_thr);
    assign tx_drain_req = tx_tail && (tx_left <= {{(16-LW){1'b0}}, tx_free});
    assign rx_req       = (rx_level >= rx_thr);
    assign rx_drain_req = rx_idle && !rx_empty && (rx_level < rx_thr);
    assign tx_dma_req   = tx_dma_en && (tx_req || tx_drain_req);
    assign rx_dma_req   = rx_dma_en && (rx_req || rx_drain_req);

    always_comb begin
        drain_cnt = '0;
        if (tx_drain_req) begin
            drain_cnt = tx_left[LW-1:0];
        end else if (rx_drain_req) begin
            drain_cnt = rx_level;
        end
    end

    // register read mux
    always_comb begin
        reg_rdata = 16'h0000;
        case (reg_addr)
            ADR_DATA: reg_rdata[7:0] = rx_head;
            ADR_CFG: begin
                reg_rdata[AW-1:0]          = tx_thr_m1;
                reg_rdata[CFG_TX_DMA]      = tx_dma_en;
                reg_rdata[CFG_RX_LSB +: AW] = rx_thr_m1;
                reg_rdata[CFG_RX_DMA]      = rx_dma_en;
            end
            ADR_STAT: begin
                reg_rdata[15:14]    = 2'(DEPTH_CODE);
                reg_rdata[STAT_OVR] = overrun_q;
                reg_rdata[STAT_UDF] = underflow_q;
                reg_rdata[LW-1:0]   = drain_cnt;
            end
            ADR_CNT: reg_rdata = cnt_q;
            ADR_LVL: begin
                reg_rdata[LW-1:0]          = tx_level;
                reg_rdata[LVL_RX_LSB +: LW] = rx_level;
            end
            default: reg_rdata = 16'h0000;
        endcase
    end
endmodule

// File: rtl/sfp_data_fifos_chk.sv
module sfp_data_fifos_chk #(
    parameter int DEPTH = 16,
    parameter int LW    = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr,
    input logic          reg_rd,
    input logic [2:0]    reg_addr,
    input logic [15:0]   reg_wdata,
    input logic          core_push,
    input logic          core_pop,
    input logic [LW-1:0] tx_level,
    input logic [LW-1:0] rx_level,
    input logic [15:0]   tx_left,
    input logic          overrun_q,
    input logic          underflow_q,
    input logic          tx_req,
    input logic          tx_drain_req
);
    logic cfg_wr;
    assign cfg_wr = reg_wr && (reg_addr == 3'd1);

    a_r2_tx_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        tx_level <= LW'(DEPTH));

    a_r12_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (core_push && rx_level == LW'(DEPTH) && !(cfg_wr && reg_wdata[14])) |=> overrun_q);

    a_r12_underflow_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (core_pop && tx_level == '0 && !(cfg_wr && reg_wdata[6])) |=> underflow_q);

    a_r5_tx_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && reg_wdata[6]) |=> (tx_level == '0 && !underflow_q));

    a_r11_count_min_one: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd3) |=> (tx_left != 16'd0));

    a_r3_empty_read_keeps_level: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 3'd0 && rx_level == '0 && !core_push) |=> (rx_level == '0));

    a_r7_ready_drain_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_req && tx_drain_req));
endmodule

bind sfp_data_fifos sfp_data_fifos_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .core_push(core_push), .core_pop(core_pop),
    .tx_level(tx_level), .rx_level(rx_level), .tx_left(tx_left),
    .overrun_q(overrun_q), .underflow_q(underflow_q),
    .tx_req(tx_req), .tx_drain_req(tx_drain_req)
);

// File: tb/sfp_data_fifos_bench.sv
`timescale 1ns/1ps
module sfp_data_fifos_bench;
    localparam int DEPTH_CODE = 1;
    localparam int DEPTH      = 8 << DEPTH_CODE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        core_push = 1'b0, core_pop = 1'b0;
    logic [7:0]  core_rx_byte = 8'd0;
    logic [7:0]  core_tx_byte;
    logic        tx_req, tx_drain_req, rx_req, rx_drain_req, tx_dma_req, rx_dma_req;

    always #2.5 clk = ~clk;

    sfp_data_fifos #(.DEPTH_CODE(DEPTH_CODE)) u_sfp_data_fifos (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .core_push(core_push), .core_rx_byte(core_rx_byte), .core_pop(core_pop),
        .core_tx_byte(core_tx_byte), .tx_req(tx_req), .tx_drain_req(tx_drain_req),
        .rx_req(rx_req), .rx_drain_req(rx_drain_req),
        .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req)
    );

    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;

    // reference model state
    int txq[$], rxq[$];
    int m_tx_left = 0, m_rx_left = 0, m_tx_ph = 0, m_rx_ph = 0;
    int m_tx_thr = 1, m_rx_thr = 1, m_cnt = 0;
    bit m_txd = 0, m_rxd = 0, m_ovr = 0, m_udf = 0;

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int phase_of(int left, int thr);
        if (left == 0) return 0;
        if (left >= thr) return 1;
        return 2;
    endfunction

    function automatic bit e_txr();
        return m_tx_ph == 1 && (DEPTH - txq.size()) >= m_tx_thr;
    endfunction
    function automatic bit e_txd();
        return m_tx_ph == 2 && (DEPTH - txq.size()) >= m_tx_left;
    endfunction
    function automatic bit e_rxr();
        return rxq.size() >= m_rx_thr;
    endfunction
    function automatic bit e_rxd();
        return m_rx_ph == 0 && rxq.size() > 0 && rxq.size() < m_rx_thr;
    endfunction
    function automatic int e_drain();
        if (e_txd()) return m_tx_left;
        if (e_rxd()) return rxq.size();
        return 0;
    endfunction
    function automatic int e_cfg();
        return (m_tx_thr - 1) | (int'(m_txd) << 7) | ((m_rx_thr - 1) << 8) | (int'(m_rxd) << 15);
    endfunction

    // compare all outputs, then advance the model across one clock edge
    task automatic tick();
        int txs, rxs, ntl, nrl;
        bit wcfg, wdat, wcnt, tclr, rclr, tpush, tpop, rpush, rpop;
        #1;
        txs = txq.size();
        rxs = rxq.size();
        chk("R7",  "tx_req",       int'(tx_req),       int'(e_txr()));
        chk("R8",  "tx_drain_req", int'(tx_drain_req), int'(e_txd()));
        chk("R9",  "rx_req",       int'(rx_req),       int'(e_rxr()));
        chk("R10", "rx_drain_req", int'(rx_drain_req), int'(e_rxd()));
        chk("R13", "tx_dma_req",   int'(tx_dma_req),   int'(m_txd && (e_txr() || e_txd())));
        chk("R13", "rx_dma_req",   int'(rx_dma_req),   int'(m_rxd && (e_rxr() || e_rxd())));
        chk("R2",  "core_tx_byte", int'(core_tx_byte), (txs > 0) ? txq[0] : 0);
        case (reg_addr)
            3'd0: chk("R3", "data port", int'(reg_rdata), (rxs > 0) ? rxq[0] : 0);
            3'd1: chk("R4", "config", int'(reg_rdata), e_cfg());
            3'd2: begin
                chk("R6",  "depth code", int'(reg_rdata[15:14]), DEPTH_CODE);
                chk("R12", "error flags", int'(reg_rdata[13:12]), (int'(m_ovr) << 1) | int'(m_udf));
                chk("R8",  "drain count", int'(reg_rdata[6:0]), e_drain());
            end
            3'd3: chk("R11", "count", int'(reg_rdata), m_cnt);
            3'd4: chk("R14", "levels", int'(reg_rdata), (rxs << 8) | txs);
            default: ;
        endcase

        wcfg  = reg_wr && reg_addr == 3'd1;
        wdat  = reg_wr && reg_addr == 3'd0;
        wcnt  = reg_wr && reg_addr == 3'd3;
        tclr  = wcfg && reg_wdata[6];
        rclr  = wcfg && reg_wdata[14];
        tpush = wdat && txs < DEPTH;
        tpop  = core_pop && txs > 0;
        rpush = core_push && rxs < DEPTH;
        rpop  = reg_rd && reg_addr == 3'd0 && rxs > 0;

        ntl = m_tx_left;
        nrl = m_rx_left;
        if (wcnt) begin
            ntl = (reg_wdata == 16'd0) ? 1 : int'(reg_wdata);
            nrl = ntl;
            m_cnt = ntl;
        end else begin
            if (tpush && ntl > 0) ntl--;
            if (core_push && nrl > 0) nrl--;
        end
        m_tx_ph = phase_of(ntl, m_tx_thr);
        m_rx_ph = phase_of(nrl, m_rx_thr);
        m_tx_left = ntl;
        m_rx_left = nrl;

        if (tclr) begin
            txq.delete();
            m_udf = 0;
        end else begin
            if (core_pop && txs == 0) m_udf = 1;
            if (tpop) void'(txq.pop_front());
            if (tpush) txq.push_back(int'(reg_wdata[7:0]));
        end
        if (rclr) begin
            rxq.delete();
            m_ovr = 0;
        end else begin
            if (core_push && rxs == DEPTH) m_ovr = 1;
            if (rpop) void'(rxq.pop_front());
            if (rpush) rxq.push_back(int'(core_rx_byte));
        end
        if (wcfg) begin
            m_tx_thr = (int'(reg_wdata) & (DEPTH - 1)) + 1;
            m_rx_thr = ((int'(reg_wdata) >> 8) & (DEPTH - 1)) + 1;
            m_txd = reg_wdata[7];
            m_rxd = reg_wdata[15];
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(bit wr, bit rd, int addr, int wdata, bit push, int pbyte, bit pop);
        reg_wr = wr;
        reg_rd = rd;
        reg_addr = 3'(addr);
        reg_wdata = 16'(wdata);
        core_push = push;
        core_rx_byte = 8'(pbyte);
        core_pop = pop;
        tick();
    endtask

    task automatic peek(int addr, string req, string what, int exp);
        reg_wr = 0; reg_rd = 0; core_push = 0; core_pop = 0;
        reg_addr = 3'(addr);
        #1;
        chk(req, what, int'(reg_rdata), exp);
        tick();
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int cfgv;
        void'($urandom(32'd7341));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        peek(4, "R1", "levels after reset", 0);
        peek(2, "R1", "status after reset", DEPTH_CODE << 14);
        peek(3, "R1", "count after reset", 0);
        peek(1, "R1", "thresholds after reset", 0);
        chk("R1", "requests after reset",
            int'({tx_req, tx_drain_req, rx_req, rx_drain_req, tx_dma_req, rx_dma_req}), 0);

        // thresholds 4/4 with DMA, transmit 10 bytes: 4+4 bulk then tail of 2
        cfgv = 3 | (1 << 7) | (3 << 8) | (1 << 15);
        drive(1, 0, 1, cfgv, 0, 0, 0);
        peek(1, "R4", "config readback", cfgv);
        drive(1, 0, 3, 10, 0, 0, 0);
        for (int i = 0; i < 10; i++) begin
            drive(1, 0, 0, 'h40 + i, 0, 0, 0);
            if (i == 7) drive(0, 0, 2, 0, 0, 0, 0);
        end
        drive(0, 0, 4, 0, 0, 0, 0);
        for (int i = 0; i < 12; i++) drive(0, 0, 2, 0, 0, 0, 1);
        peek(2, "R12", "underflow after empty pops", (DEPTH_CODE << 14) | (1 << 12));

        // receive 6 bytes then drain the final partial chunk
        drive(1, 0, 3, 6, 0, 0, 0);
        for (int i = 0; i < 6; i++) drive(0, 0, 2, 0, 1, 'h90 + i, 0);
        for (int i = 0; i < 7; i++) drive(0, 1, (i % 2 == 0) ? 0 : 0, 0, 0, 0, 0);
        peek(0, "R3", "empty read returns 0", 0);
        peek(4, "R3", "level stays 0 after empty read", 0);

        // overrun: push past full
        drive(1, 0, 3, 40, 0, 0, 0);
        for (int i = 0; i < DEPTH + 2; i++) drive(0, 0, 2, 0, 1, i, 0);
        peek(2, "R12", "overrun flag", (DEPTH_CODE << 14) | (1 << 13) | (1 << 12));

        // clears
        drive(1, 0, 1, cfgv | (1 << 14), 0, 0, 0);
        peek(4, "R5", "rx cleared", 0);
        drive(1, 0, 0, 'h11, 0, 0, 0);
        drive(1, 0, 1, cfgv | (1 << 6), 0, 0, 0);
        peek(2, "R5", "flags cleared", DEPTH_CODE << 14);
        peek(1, "R5", "clear bits read 0", cfgv);

        // zero count loads one
        drive(1, 0, 3, 0, 0, 0, 0);
        peek(3, "R11", "count of 0 loads 1", 1);

        // constrained random traffic
        for (int c = 0; c < 6000; c++) begin
            int r;
            r = int'($urandom % 100);
            if (c % 700 == 0) begin
                drive(1, 0, 1, int'($urandom) & 'h8F8F & ~'h4040, 0, 0, 0);
            end else if (c % 300 == 0) begin
                drive(1, 0, 3, int'($urandom % 41), 0, 0, 0);
            end else if (r < 10) begin
                drive(1, 0, 0, int'($urandom % 256), 0, 0, 1);
            end else if (r < 35) begin
                drive(1, 0, 0, int'($urandom % 256), 0, 0, 0);
            end else if (r < 50) begin
                drive(0, 0, 2, 0, 0, 0, 1);
            end else if (r < 70) begin
                drive(0, 0, 4, 0, 1, int'($urandom % 256), 0);
            end else if (r < 85) begin
                drive(0, 1, 0, 0, 0, 0, 0);
            end else begin
                drive(0, 0, 1 + int'($urandom % 4), 0, 0, 0, 0);
            end
        end

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule